// File: doc/BRIEF.md
# CompactPCI Board Hot-Swap Control

This block is the board-side half of the live-insertion handshake on a CompactPCI card. It watches the ejector-handle microswitch and turns each settled movement of the handle into a pending event bit. Locking the handle after the board is seated gives an insertion event. Unlocking it before the board moves gives an extraction event. A pending event that is not masked pulls the open-drain enumeration line low, so system software knows it should rescan the bus. Software acknowledges an event by writing a one to its bit. Software also drives the blue status LED, which it lights once the board is quiesced and safe to pull.

The handle input is first synchronised and then debounced. A state machine (`HS_OPEN`, `HS_LOCK_EVT`, `HS_LOCKED`, `HS_UNLOCK_EVT`) follows the settled handle level and emits a one-cycle pulse on each edge. The debouncer has its own two states. In `DB_STEADY` the settled level matches the input. In `DB_TIMING` the two differ and a counter runs. The counter returns the debouncer to `DB_STEADY` either by adopting the new level after `DEB_CYCLES` unbroken clocks or by dropping it if the input bounces back. The handle machine moves `HS_OPEN→HS_LOCK_EVT` on a settled lock and `HS_LOCK_EVT→HS_LOCKED` one cycle later. It moves `HS_LOCKED→HS_UNLOCK_EVT` on a settled unlock and `HS_UNLOCK_EVT→HS_OPEN` one cycle later. From an event state, a reversed level goes straight to the opposite event state.

Back-end application power follows the backplane board-select input, which is active low and pulled high on the card, through a two-stage synchroniser. A single 8-bit register with a write strobe and a continuously presented read value stands in for configuration-space access.

Top module: `hsw_board_ctrl`

## Requirements
- R1: The ejector-switch input counts only after it has held a new level for `DEB_CYCLES` consecutive clocks (default 1024) after a two-flop synchroniser. Shorter pulses and bouncing produce no event.
- R2: The insertion bit (register bit 0) sets only on a settled transition of the handle to locked (input 1). After such a transition it becomes visible `DEB_CYCLES`+4 clock edges after the input changes.
- R3: The extraction bit (register bit 1) sets only on a settled transition of the handle to unlocked (input 0), with the same latency as R2.
- R4: `enum_drive_low_o` is 1 exactly when bit 0 or bit 1 is pending and the mask bit (bit 3) is 0. The line is released otherwise and is never driven high.
- R5: Writing a one to bit 0 or bit 1 clears that bit, and writing zero leaves it unchanged. If a hardware set and a clearing write land in the same cycle, the set wins.
- R6: `led_o` equals register bit 2, which software writes directly.
- R7: Reset leaves bit 2 at 1, and every insertion event forces bit 2 to 1, overriding a write in the same cycle. An extraction event leaves bit 2 unchanged.
- R8: `backend_pwr_en_o` is 1 only while `bdsel_n_i` is low. It follows the input after two clock edges.
- R9: Register layout: bit 0 insertion, bit 1 extraction, bit 2 LED, bit 3 enumeration mask. Bits 7:4 read 0. Reset value is 0x04.
- R10: The two event bits are independent. Both may be pending together, and clearing one leaves the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| handle_sw_i | input | 1 | Ejector switch, 1 = handle locked with the board seated |
| bdsel_n_i | input | 1 | Backplane board select, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Current register value |
| enum_drive_low_o | output | 1 | Open-drain enable: 1 pulls the enumeration line low |
| led_o | output | 1 | Blue status LED |
| backend_pwr_en_o | output | 1 | Back-end application power enable |

## Verification
The bench feeds a short pulse and a burst of bounces into the handle input. A debouncer that restarts its count wrongly, or that never restarts, would raise a spurious event there. Around a clean lock and unlock it samples the edge just before the event bit must appear and the edge at which it must appear, so a counter that is off by one shows up. It times a clearing write to land in the same cycle as an insertion pulse, where a design giving priority to the clear would lose the event and leave the LED dark. It also checks the mask with an extraction still pending, writes zero to pending bits, and clears one bit while both are pending, to catch masks that erase state, write-zero clears and bits coupled to each other.

// File: rtl/hsw_pkg.sv
package hsw_pkg;
    // Register field positions (software-visible layout)
    localparam int BIT_INS  = 0;
    localparam int BIT_EXT  = 1;
    localparam int BIT_LED  = 2;
    localparam int BIT_MASK = 3;
    localparam int FIELD_CNT = 4;

    // Depth of every clock-domain synchroniser in the block
    localparam int SYNC_STAGES = 2;

    typedef enum logic [1:0] {
        HS_OPEN,
        HS_LOCK_EVT,
        HS_LOCKED,
        HS_UNLOCK_EVT
    } hs_state_e;

    typedef enum logic {
        DB_STEADY,
        DB_TIMING
    } db_state_e;
endpackage

// File: rtl/hsw_sync.sv
module hsw_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= {STAGES{RST_VAL}};
        end else begin
            chain <= {chain[STAGES-2:0], d_i};
        end
    end

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/hsw_debounce.sv
module hsw_debounce
    import hsw_pkg::*;
#(
    parameter int DEB_CYCLES = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic level_o
);
    localparam int CW = $clog2(DEB_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(DEB_CYCLES - 1);

    db_state_e     state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          level_q, level_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= DB_STEADY;
            cnt_q   <= '0;
            level_q <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            level_q <= level_d;
        end
    end

    // Next state: run a window while input differs from the settled level
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        level_d = level_q;
        unique case (state_q)
            DB_STEADY: begin
                cnt_d = '0;
                if (raw_i != level_q) begin
                    state_d = DB_TIMING;
                    cnt_d   = CW'(1);
                end
            end
            DB_TIMING: begin
                if (raw_i == level_q) begin
                    state_d = DB_STEADY;
                    cnt_d   = '0;
                end else if (cnt_q == LAST) begin
                    state_d = DB_STEADY;
                    cnt_d   = '0;
                    level_d = raw_i;
                end else begin
                    cnt_d = cnt_q + CW'(1);
                end
            end
            default: begin
                state_d = DB_STEADY;
                cnt_d   = '0;
            end
        endcase
    end

    // Output
    assign level_o = level_q;
endmodule

// File: rtl/hsw_handle_fsm.sv
module hsw_handle_fsm
    import hsw_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic locked_i,
    output logic ins_pulse_o,
    output logic ext_pulse_o
);
    hs_state_e state_q, state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= HS_OPEN;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            HS_OPEN:       if (locked_i)  state_d = HS_LOCK_EVT;
            HS_LOCK_EVT:   state_d = locked_i ? HS_LOCKED : HS_UNLOCK_EVT;
            HS_LOCKED:     if (!locked_i) state_d = HS_UNLOCK_EVT;
            HS_UNLOCK_EVT: state_d = locked_i ? HS_LOCK_EVT : HS_OPEN;
            default:       state_d = HS_OPEN;
        endcase
    end

    // Outputs: one-cycle event pulses decoded from state
    always_comb begin
        ins_pulse_o = 1'b0;
        ext_pulse_o = 1'b0;
        unique case (state_q)
            HS_LOCK_EVT:   ins_pulse_o = 1'b1;
            HS_UNLOCK_EVT: ext_pulse_o = 1'b1;
            default: begin
                ins_pulse_o = 1'b0;
                ext_pulse_o = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/hsw_csr.sv
module hsw_csr
    import hsw_pkg::*;
#(
    parameter int REG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ins_set_i,
    input  logic             ext_set_i,
    input  logic             wr_i,
    input  logic [REG_W-1:0] wdata_i,
    output logic             ins_o,
    output logic             ext_o,
    output logic             led_o,
    output logic             mask_o,
    output logic [REG_W-1:0] rdata_o
);
    logic ins_q, ext_q, led_q, mask_q;
    logic clr_ins, clr_ext;
    logic unused_wr_hi;

    assign clr_ins = wr_i & wdata_i[BIT_INS];
    assign clr_ext = wr_i & wdata_i[BIT_EXT];
    assign unused_wr_hi = ^wdata_i[REG_W-1:FIELD_CNT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ins_q  <= 1'b0;
            ext_q  <= 1'b0;
            led_q  <= 1'b1;
            mask_q <= 1'b0;
        end else begin
            // hardware set has priority over write-one-to-clear
            ins_q <= ins_set_i | (ins_q & ~clr_ins);
            ext_q <= ext_set_i | (ext_q & ~clr_ext);
            if (ins_set_i) begin
                led_q <= 1'b1;
            end else if (wr_i) begin
                led_q <= wdata_i[BIT_LED];
            end
            if (wr_i) begin
                mask_q <= wdata_i[BIT_MASK];
            end
        end
    end

    always_comb begin
        rdata_o           = '0;
        rdata_o[BIT_INS]  = ins_q;
        rdata_o[BIT_EXT]  = ext_q;
        rdata_o[BIT_LED]  = led_q;
        rdata_o[BIT_MASK] = mask_q;
    end

    assign ins_o  = ins_q;
    assign ext_o  = ext_q;
    assign led_o  = led_q;
    assign mask_o = mask_q;
endmodule

// File: rtl/hsw_board_ctrl.sv
module hsw_board_ctrl
    import hsw_pkg::*;
#(
    parameter int DEB_CYCLES = 1024,
    parameter int REG_W      = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             handle_sw_i,
    input  logic             bdsel_n_i,
    input  logic             reg_wr_i,
    input  logic [REG_W-1:0] reg_wdata_i,
    output logic [REG_W-1:0] reg_rdata_o,
    output logic             enum_drive_low_o,
    output logic             led_o,
    output logic             backend_pwr_en_o
);
    logic handle_sync;
    logic handle_stable;
    logic bdsel_n_sync;
    logic ins_pulse, ext_pulse;
    logic ins_pend, ext_pend, led_bit, mask_bit;

    hsw_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_handle (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (handle_sw_i),
        .q_o   (handle_sync)
    );

    hsw_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_bdsel (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (bdsel_n_i),
        .q_o   (bdsel_n_sync)
    );

    hsw_debounce #(.DEB_CYCLES(DEB_CYCLES)) u_deb (
        .clk     (clk),
        .rst_n   (rst_n),
        .raw_i   (handle_sync),
        .level_o (handle_stable)
    );

    hsw_handle_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .locked_i    (handle_stable),
        .ins_pulse_o (ins_pulse),
        .ext_pulse_o (ext_pulse)
    );

    hsw_csr #(.REG_W(REG_W)) u_csr (
        .clk       (clk),
        .rst_n     (rst_n),
        .ins_set_i (ins_pulse),
        .ext_set_i (ext_pulse),
        .wr_i      (reg_wr_i),
        .wdata_i   (reg_wdata_i),
        .ins_o     (ins_pend),
        .ext_o     (ext_pend),
        .led_o     (led_bit),
        .mask_o    (mask_bit),
        .rdata_o   (reg_rdata_o)
    );

    assign enum_drive_low_o = (ins_pend | ext_pend) & ~mask_bit;
    assign led_o            = led_bit;
    assign backend_pwr_en_o = ~bdsel_n_sync;
endmodule

// File: rtl/hsw_board_ctrl_chk.sv
module hsw_board_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic bdsel_n_i,
    input logic reg_wr_i,
    input logic wr_ins_bit,
    input logic ins_pend,
    input logic ext_pend,
    input logic mask_bit,
    input logic enum_drive_low_o,
    input logic led_o,
    input logic backend_pwr_en_o,
    input logic ins_pulse,
    input logic ext_pulse,
    input logic handle_stable
);
    AST_DEB_MIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (handle_stable != $past(handle_stable)) |=> $stable(handle_stable)); // R1
    AST_INS_FROM_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ins_pend) |-> $past(ins_pulse)); // R2
    AST_LOCK_PULSE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        ins_pulse |-> handle_stable); // R2
    AST_EXT_FROM_UNLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ext_pend) |-> $past(ext_pulse)); // R3
    AST_UNLOCK_PULSE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        ext_pulse |-> !handle_stable); // R3
    AST_ENUM_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        enum_drive_low_o |-> ((ins_pend || ext_pend) && !mask_bit)); // R4
    AST_ZERO_WRITE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_i && !wr_ins_bit && ins_pend) |=> ins_pend); // R5
    AST_ONE_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_i && wr_ins_bit && !ins_pulse) |=> !ins_pend); // R5
    AST_LED_ON_INSERT: assert property (@(posedge clk) disable iff (!rst_n)
        ins_pulse |=> led_o); // R7
    AST_EVENTS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(ins_pulse && ext_pulse)); // R10
    AST_PWR_NEEDS_BDSEL: assert property (@(posedge clk) disable iff (!rst_n)
        backend_pwr_en_o |-> !$past(bdsel_n_i, 2)); // R8
endmodule

bind hsw_board_ctrl hsw_board_ctrl_chk u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .bdsel_n_i        (bdsel_n_i),
    .reg_wr_i         (reg_wr_i),
    .wr_ins_bit       (reg_wdata_i[0]),
    .ins_pend         (ins_pend),
    .ext_pend         (ext_pend),
    .mask_bit         (mask_bit),
    .enum_drive_low_o (enum_drive_low_o),
    .led_o            (led_o),
    .backend_pwr_en_o (backend_pwr_en_o),
    .ins_pulse        (ins_pulse),
    .ext_pulse        (ext_pulse),
    .handle_stable    (handle_stable)
);

// File: tb/sim_hsw_board_ctrl.sv
module sim_hsw_board_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int DB         = 32;
    localparam int WD_CYCLES  = 50000;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       handle_sw;
    logic       bdsel_n;
    logic       reg_wr;
    logic [7:0] reg_wdata;
    logic [7:0] reg_rdata;
    logic       enum_lo;
    logic       led;
    logic       pwr;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    // bench-side model of the register
    logic m_ins = 1'b0, m_ext = 1'b0, m_led = 1'b1, m_mask = 1'b0, m_pwr = 1'b0;

    typedef struct {
        string      tag;
        logic [7:0] rd;
        logic       en;
        logic       ld;
        logic       pw;
    } exp_t;

    exp_t sbq[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    hsw_board_ctrl #(.DEB_CYCLES(DB), .REG_W(8)) u0 (
        .clk              (clk),
        .rst_n            (rst_n),
        .handle_sw_i      (handle_sw),
        .bdsel_n_i        (bdsel_n),
        .reg_wr_i         (reg_wr),
        .reg_wdata_i      (reg_wdata),
        .reg_rdata_o      (reg_rdata),
        .enum_drive_low_o (enum_lo),
        .led_o            (led),
        .backend_pwr_en_o (pwr)
    );

    // Driver side: push the model's current view
    task automatic expect_now(input string tag);
        exp_t e;
        e.tag = tag;
        e.rd  = {4'b0000, m_mask, m_led, m_ext, m_ins};
        e.en  = (m_ins | m_ext) & ~m_mask;
        e.ld  = m_led;
        e.pw  = m_pwr;
        sbq.push_back(e);
    endtask

    task automatic wait_neg(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_handle(input logic v);
        @(negedge clk);
        handle_sw = v;
    endtask

    task automatic wr_reg(input logic [7:0] d);
        @(negedge clk);
        reg_wr    = 1'b1;
        reg_wdata = d;
        @(negedge clk);
        reg_wr    = 1'b0;
        reg_wdata = 8'h00;
        if (d[0]) m_ins = 1'b0;
        if (d[1]) m_ext = 1'b0;
        m_led  = d[2];
        m_mask = d[3];
    endtask

    // Monitor: pops expected items and compares away from the edge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (sbq.size() > 0) begin
                exp_t e;
                e = sbq.pop_front();
                vectors++;
                if (reg_rdata !== e.rd || enum_lo !== e.en || led !== e.ld || pwr !== e.pw) begin
                    errors++;
                    $display("FAIL %s: rdata=%h enum=%b led=%b pwr=%b, expected rdata=%h enum=%b led=%b pwr=%b",
                             e.tag, reg_rdata, enum_lo, led, pwr, e.rd, e.en, e.ld, e.pw);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run still active after %0d cycles, expected completion", WD_CYCLES);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        rst_n     = 1'b0;
        handle_sw = 1'b0;
        bdsel_n   = 1'b1;
        reg_wr    = 1'b0;
        reg_wdata = 8'h00;
        wait_neg(5);
        rst_n = 1'b1;
        @(negedge clk);
        expect_now("R9 reset value 0x04, R7 LED lit at reset");

        // R8: back-end power follows board select after two edges
        @(negedge clk);
        bdsel_n = 1'b0;
        @(negedge clk);
        expect_now("R8 power still off after one edge");
        @(negedge clk);
        m_pwr = 1'b1;
        expect_now("R8 power on after select low");

        // R1: a short pulse is ignored
        set_handle(1'b1);
        wait_neg(DB/2);
        set_handle(1'b0);
        wait_neg(DB + 10);
        expect_now("R1 short pulse ignored");

        // R1: bounce burst ignored
        for (int i = 0; i < 6; i++) begin
            set_handle(1'b1);
            wait_neg(4);
            set_handle(1'b0);
            wait_neg(4);
        end
        wait_neg(DB + 10);
        expect_now("R1 bounce ignored");

        // R2: clean lock, sample one edge before and at the event
        set_handle(1'b1);
        wait_neg(DB + 3);
        expect_now("R1 R2 insertion not yet visible");
        @(negedge clk);
        m_ins = 1'b1;
        m_led = 1'b1;
        expect_now("R2 insertion bit set, R4 enum low");

        wr_reg(8'h04);
        expect_now("R5 write zero keeps insertion");
        wr_reg(8'h00);
        expect_now("R6 software turns LED off");
        wr_reg(8'h01);
        expect_now("R5 write one clears insertion, R4 released");
        wr_reg(8'h04);
        expect_now("R6 software lights LED");
        wr_reg(8'h00);
        expect_now("R6 LED off again");

        // R3: unlock
        set_handle(1'b0);
        wait_neg(DB + 3);
        expect_now("R3 extraction not yet visible");
        @(negedge clk);
        m_ext = 1'b1;
        expect_now("R3 extraction set, R7 LED untouched");

        // R4: mask
        wr_reg(8'h08);
        expect_now("R4 mask releases enum, extraction kept");
        wr_reg(8'h00);
        expect_now("R4 unmask drives enum low again");

        // R10: both pending, clear one
        set_handle(1'b1);
        wait_neg(DB + 4);
        m_ins = 1'b1;
        m_led = 1'b1;
        expect_now("R10 both pending, R7 LED forced on");
        wr_reg(8'h06);
        expect_now("R10 clearing extraction keeps insertion");

        // R9: upper bits read zero
        wr_reg(8'hFC);
        expect_now("R9 upper bits read zero, R4 masked");

        // clean up then race set against clear
        wr_reg(8'h01);
        expect_now("R5 clear before race");
        set_handle(1'b0);
        wait_neg(DB + 4);
        m_ext = 1'b1;
        expect_now("R3 extraction before race");
        wr_reg(8'h02);
        expect_now("R5 extraction cleared");
        set_handle(1'b1);
        wait_neg(DB + 2);
        wr_reg(8'h01);
        m_ins = 1'b1;
        m_led = 1'b1;
        expect_now("R5 set wins over same-cycle clear, R7 LED forced");

        // R8: deselect
        @(negedge clk);
        bdsel_n = 1'b1;
        wait_neg(2);
        m_pwr = 1'b0;
        expect_now("R8 power off after select high");

        wait_neg(3);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule